// File: doc/BRIEF.md
# Time-Shared Doppler Shaping FIR Engine

This block is a long fixed-point low-pass FIR used to shape white noise into a fading process for channel emulation. Because the shaped process runs at a very low sample rate, one instance serves many channel paths in turn. Each accepted 16-bit Q1.15 sample is written into a circular history of the last 500 inputs. The block then convolves that history with a programmable set of up to 500 Q1.15 coefficients, using ten multiply-accumulate lanes in parallel. Lane k takes taps k, k+10, k+20 and so on.

Work advances only on enable ticks from a programmable divider, so the arithmetic can be paced well below the master clock. The divider is held in reset whenever no sample is in flight. The input and output are valid/ready streams with exactly one sample in flight. While a sample is being processed, or while its result waits for the consumer, `in_ready` stays low, so a producer is held off rather than losing data. A result is held on `out_data` until `out_ready` takes it. Coefficients are loaded through a simple write port that only acts while the engine is idle. The tap count is sampled each time a sample is accepted.

Top module: `fade_fir_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1. The history and all coefficients read as zero.
- R2: For an accepted sample, the result is the sum over taps j < N of coef[j]·x[n−j], where x[n] is the newest sample and older history reads as zero after reset. Both operands are signed Q1.15. The result is rounded by adding 2^14 to the Q2.30 sum and then shifting it arithmetically right by 15.
- R3: A rounded result above 32767 is output as 32767. A rounded result below −32768 is output as −32768.
- R4: With `cfg_skip` = S held stable, one enable tick occurs every S+1 clock cycles while busy. `out_valid` rises exactly (ceil(N/10)+1)·(S+1) cycles after the accepting clock edge.
- R5: `in_ready` is 1 only when the engine is idle. It drops in the cycle after acceptance and stays low until the result has been taken. A sample offered in the same cycle that the previous result is taken is therefore accepted one cycle later.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged. After a cycle with both high, `out_valid` is 0.
- R7: A coefficient write (`coef_we`, `coef_addr`, `coef_data`) takes effect only in a cycle where `in_ready` is 1. Such a write counts even in the very cycle a sample is accepted, and that sample then uses the new value. A write while busy or holding a result is ignored.
- R8: `cfg_taps` is sampled at acceptance. A value of 0 acts as 1, and a value above 500 acts as 500. The sampled tap count sets both the result and the latency of R4.
- R9: The history always holds the last 500 accepted samples, whatever tap counts earlier samples used. Raising N therefore brings in older real samples rather than zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a sample |
| in_ready | output | 1 | Engine idle and able to accept |
| in_data | input | 16 | Q1.15 input sample |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Q1.15 filtered result |
| cfg_taps | input | 9 | Tap count, clamped to 1..500 |
| cfg_skip | input | 8 | Divider setting: one tick every cfg_skip+1 cycles |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 9 | Coefficient index (tap number) |
| coef_data | input | 16 | Q1.15 coefficient value |

## Verification
Two events can fall in the same cycle: the consumer taking a held result, and the producer offering the next sample. The bench stalls the output, then raises `out_ready` and `in_valid` together. It judges the outcome by the next acceptance landing exactly one cycle after the output handshake. The second collision is a coefficient write in the same cycle that a sample is accepted. The scoreboard's expected value uses the new coefficient, so the write must land before the first MAC step reads it. A companion write issued mid-computation must leave the following result at the old coefficient's value.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUM  = 2'd2,
    ST_HOLD = 2'd3
  } fir_state_e;
endpackage

// File: rtl/fir_tick_gen.sv
// Programmable enable divider: one tick every skip+1 cycles while run is high.
module fir_tick_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] skip,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == skip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + DIVW'(1);
  end
endmodule

// File: rtl/fir_tap_store.sv
// Coefficient and history register files, one write port each, NRD read ports each.
module fir_tap_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 500,
  parameter int NRD   = 10,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cw_en,
  input  logic [AW-1:0]        cw_addr,
  input  logic [DW-1:0]        cw_data,
  input  logic                 hw_en,
  input  logic [AW-1:0]        hw_addr,
  input  logic [DW-1:0]        hw_data,
  input  logic [AW-1:0]        c_raddr [NRD],
  input  logic [AW-1:0]        h_raddr [NRD],
  output logic signed [DW-1:0] c_rdata [NRD],
  output logic signed [DW-1:0] h_rdata [NRD]
);
  logic [DW-1:0] cmem [DEPTH];
  logic [DW-1:0] hmem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cmem[i] <= '0;
    end else if (cw_en) begin
      cmem[cw_addr] <= cw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hmem[i] <= '0;
    end else if (hw_en) begin
      hmem[hw_addr] <= hw_data;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign c_rdata[r] = cmem[c_raddr[r]];
    assign h_rdata[r] = hmem[h_raddr[r]];
  end
endmodule

// File: rtl/fir_mac_lane.sv
// One multiply-accumulate lane with sign-extended Q2.30 products.
module fir_mac_lane #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic                   live,
  input  logic signed [DW-1:0]   coef,
  input  logic signed [DW-1:0]   samp,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = 2 * DW;
  logic signed [PW-1:0] prod;

  assign prod = coef * samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           acc <= '0;
    else if (clr)         acc <= '0;
    else if (en && live)  acc <= acc + {{(ACCW-PW){prod[PW-1]}}, prod};
  end
endmodule

// File: rtl/fir_reduce.sv
// Sums lane accumulators, rounds Q2.30 to Q1.15 and saturates.
module fir_reduce #(
  parameter int NLANE = 10,
  parameter int ACCW  = 40,
  parameter int DW    = 16,
  parameter int FRAC  = 15
) (
  input  logic signed [ACCW-1:0] acc_in [NLANE],
  output logic signed [DW-1:0]   y
);
  localparam int SUMW = ACCW + $clog2(NLANE + 1);
  localparam logic signed [SUMW-1:0] MAXV = {{(SUMW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SUMW-1:0] MINV = ~MAXV;
  localparam logic signed [SUMW-1:0] HALF = {{(SUMW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [SUMW-1:0] total;
  logic signed [SUMW-1:0] shf;

  always_comb begin
    total = '0;
    for (int i = 0; i < NLANE; i++)
      total = total + {{(SUMW-ACCW){acc_in[i][ACCW-1]}}, acc_in[i]};
    shf = (total + HALF) >>> FRAC;
    if (shf > MAXV)      y = MAXV[DW-1:0];
    else if (shf < MINV) y = MINV[DW-1:0];
    else                 y = shf[DW-1:0];
  end
endmodule

// File: rtl/fade_fir_engine.sv
module fade_fir_engine #(
  parameter int DW       = 16,
  parameter int MAX_TAPS = 500,
  parameter int LANES    = 10,
  parameter int ACC_W    = 40,
  parameter int DIV_W    = 8,
  localparam int AW        = $clog2(MAX_TAPS),
  localparam int TW        = $clog2(MAX_TAPS + 1),
  localparam int STEPS_MAX = (MAX_TAPS + LANES - 1) / LANES,
  localparam int SW        = $clog2(STEPS_MAX + 1),
  localparam int JW        = $clog2(2 * MAX_TAPS + LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  input  logic [TW-1:0]    cfg_taps,
  input  logic [DIV_W-1:0] cfg_skip,
  input  logic             coef_we,
  input  logic [AW-1:0]    coef_addr,
  input  logic [DW-1:0]    coef_data
);
  import fir_pkg::*;

  fir_state_e state;
  logic [AW-1:0] wp, head;
  logic [TW-1:0] ntaps, taps_eff;
  logic [SW-1:0] step, last_step, steps_eff;
  logic [DW-1:0] out_q;
  logic          tick, accept, mac_en;
  logic signed [DW-1:0] sum_y;

  logic [AW-1:0]           c_raddr [LANES];
  logic [AW-1:0]           h_raddr [LANES];
  logic signed [DW-1:0]    c_rdata [LANES];
  logic signed [DW-1:0]    h_rdata [LANES];
  logic signed [ACC_W-1:0] lane_acc [LANES];
  logic                    lane_live [LANES];

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign out_data  = out_q;
  assign accept    = in_valid && (state == ST_IDLE);
  assign mac_en    = (state == ST_RUN) && tick;

  // Tap count clamp and the index of the last MAC step
  always_comb begin
    if (cfg_taps == '0)                 taps_eff = TW'(1);
    else if (cfg_taps > TW'(MAX_TAPS))  taps_eff = TW'(MAX_TAPS);
    else                                taps_eff = cfg_taps;
    steps_eff = SW'((taps_eff - TW'(1)) / TW'(LANES));
  end

  fir_tick_gen #(.DIVW(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((state == ST_RUN) || (state == ST_SUM)),
    .skip (cfg_skip),
    .tick (tick)
  );

  fir_tap_store #(.DW(DW), .DEPTH(MAX_TAPS), .NRD(LANES), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .cw_en  (coef_we && (state == ST_IDLE) && (coef_addr < AW'(MAX_TAPS))),
    .cw_addr(coef_addr),
    .cw_data(coef_data),
    .hw_en  (accept),
    .hw_addr(wp),
    .hw_data(in_data),
    .c_raddr(c_raddr),
    .h_raddr(h_raddr),
    .c_rdata(c_rdata),
    .h_rdata(h_rdata)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [JW-1:0] tap_j;
    always_comb begin
      tap_j        = JW'(step) * JW'(LANES) + JW'(k);
      lane_live[k] = tap_j < JW'(ntaps);
      c_raddr[k]   = lane_live[k] ? tap_j[AW-1:0] : '0;
      if (!lane_live[k])             h_raddr[k] = '0;
      else if (JW'(head) >= tap_j)   h_raddr[k] = AW'(JW'(head) - tap_j);
      else                           h_raddr[k] = AW'(JW'(head) + JW'(MAX_TAPS) - tap_j);
    end

    fir_mac_lane #(.DW(DW), .ACCW(ACC_W)) u_mac (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (accept),
      .en   (mac_en),
      .live (lane_live[k]),
      .coef (c_rdata[k]),
      .samp (h_rdata[k]),
      .acc  (lane_acc[k])
    );
  end

  fir_reduce #(.NLANE(LANES), .ACCW(ACC_W), .DW(DW), .FRAC(DW-1)) u_reduce (
    .acc_in(lane_acc),
    .y     (sum_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wp        <= '0;
      head      <= '0;
      ntaps     <= TW'(1);
      last_step <= '0;
      step      <= '0;
      out_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          head      <= wp;
          wp        <= (wp == AW'(MAX_TAPS - 1)) ? '0 : wp + AW'(1);
          ntaps     <= taps_eff;
          last_step <= steps_eff;
          step      <= '0;
          state     <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (step == last_step) state <= ST_SUM;
          else                   step  <= step + SW'(1);
        end
        ST_SUM: if (tick) begin
          out_q <= sum_y;
          state <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fade_fir_engine_chk.sv
module fade_fir_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

  p_one_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_accept_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

bind fade_fir_engine fade_fir_engine_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/sim_fade_fir_engine.sv
module sim_fade_fir_engine;
  localparam int DW = 16, MAXT = 500, LANES = 10, DIVW = 8;
  localparam int AW = $clog2(MAXT), TW = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0, out_data;
  logic [TW-1:0] cfg_taps = '0;
  logic [DIVW-1:0] cfg_skip = '0;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [DW-1:0] coef_data = '0;

  always #10 clk = ~clk;

  fade_fir_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cfg_taps(cfg_taps), .cfg_skip(cfg_skip),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int last_acc = 0, last_rise = 0, last_hs = 0, rdy_mode = 0, cur_taps = 1;
  longint last_out = 0;
  longint mcoef [MAXT];
  longint hist [MAXT];
  int mwp = 0, mhead = 0;
  longint exp_q [$];
  string  tag_q [$];
  logic   ov_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int clamp_taps(input int t);
    if (t == 0) return 1;
    if (t > MAXT) return MAXT;
    return t;
  endfunction

  function automatic longint model_out(input int n);
    longint s = 0, r;
    for (int j = 0; j < n; j++) s += mcoef[j] * hist[(mhead - j + MAXT) % MAXT];
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic step_clk;
    @(posedge clk); #1;
  endtask

  task automatic wcoef(input int a, input int v);
    coef_we = 1'b1; coef_addr = AW'(a); coef_data = v[15:0];
    mcoef[a] = v;
    step_clk();
    coef_we = 1'b0;
  endtask

  task automatic set_cfg(input int taps, input int skip);
    cfg_taps = TW'(taps); cfg_skip = DIVW'(skip); cur_taps = taps;
  endtask

  // Driver: offers a sample, waits for acceptance, pushes the expected result
  task automatic send(input int x, input string tag);
    in_data = x[15:0]; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    hist[mwp] = x; mhead = mwp; mwp = (mwp + 1) % MAXT;
    exp_q.push_back(model_out(clamp_taps(cur_taps)));
    tag_q.push_back(tag);
    last_acc = cyc + 1;
    step_clk();
    in_valid = 1'b0; coef_we = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    step_clk(); step_clk();
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom_range(0, 2) != 0);
      default: out_ready = 1'b0;
    endcase
  end

  // Monitor: scoreboard compare at each output handshake
  always @(negedge clk) if (rst_n) begin
    if (out_valid && !ov_prev) last_rise = cyc;
    ov_prev = out_valid;
    if (out_valid && out_ready) begin
      last_hs = cyc + 1;
      last_out = longint'($signed(out_data));
      if (exp_q.size() == 0) chk("R2 unexpected output", 1, 0);
      else begin
        string t;
        longint e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, longint'($signed(out_data)), e);
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    for (int i = 0; i < MAXT; i++) begin mcoef[i] = 0; hist[i] = 0; end
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    step_clk();

    // R1 zero state: one tap, no coefficient loaded, nonzero sample gives 0
    set_cfg(1, 0);
    send(12345, "R1 zero coefficients");
    drain();
    chk("R1 zero result", last_out, 0);

    // R2/R4: short filter, full-rate ticks
    for (int j = 0; j < 12; j++) wcoef(j, 3000 - 700 * j);
    set_cfg(4, 0);
    send(12000, "R2 taps4 a");
    drain();
    chk("R4 latency taps4 skip0", last_rise - last_acc, 2);
    send(-5000, "R2 taps4 b");
    send(32767, "R2 taps4 c");
    send(-32768, "R2 taps4 d");
    send(1, "R2 taps4 e");
    drain();

    // R4: 25 taps, skip 3, then random back-pressure
    for (int j = 0; j < 25; j++) wcoef(j, ((j * 1371) % 9000) - 4500);
    set_cfg(25, 3);
    send(7777, "R2 taps25 a");
    drain();
    chk("R4 latency taps25 skip3", last_rise - last_acc, 16);
    rdy_mode = 1;
    send(-20000, "R2 taps25 b");
    send(31000, "R2 taps25 c");
    send(-3, "R2 taps25 d");
    drain();
    rdy_mode = 0;

    // R3: saturation both ways
    for (int j = 0; j < 4; j++) wcoef(j, 32767);
    set_cfg(4, 0);
    for (int i = 0; i < 4; i++) send(32767, "R3 positive run");
    drain();
    chk("R3 positive clip", last_out, 32767);
    for (int i = 0; i < 4; i++) send(-32768, "R3 negative run");
    drain();
    chk("R3 negative clip", last_out, -32768);

    // R5/R6: stalled output, then handshake and new offer in the same cycle
    set_cfg(4, 0);
    rdy_mode = 2;
    step_clk();
    send(9000, "R6 held result");
    do @(negedge clk); while (!out_valid);
    held = out_data;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6 valid held", out_valid, 1);
      chk("R6 data stable", out_data, held);
      chk("R5 in_ready low while holding", in_ready, 0);
    end
    @(posedge clk); #1;
    rdy_mode = 0;
    send(-4321, "R5 collided offer");
    chk("R5 accept one cycle after handshake", last_acc - last_hs, 1);
    drain();

    // R7: write while busy ignored; write in accept cycle applied
    for (int j = 0; j < 10; j++) wcoef(j, 2000 + 100 * j);
    wcoef(0, 4000);
    set_cfg(10, 0);
    for (int i = 0; i < 10; i++) send(0, "R7 flush");
    drain();
    set_cfg(10, 20);
    send(1000, "R7 pre-write");
    coef_we = 1'b1; coef_addr = AW'(0); coef_data = 16'd12345;
    step_clk();
    coef_we = 1'b0;
    chk("R7 write issued while busy", in_ready, 0);
    drain();
    send(0, "R7 busy write ignored");
    drain();
    chk("R7 coefficient unchanged", last_out, (4000 * 0 + 2100 * 1000 + 16384) >>> 15);
    coef_we = 1'b1; coef_addr = AW'(1); coef_data = 16'(-2222);
    mcoef[1] = -2222;
    send(500, "R7 write in accept cycle");
    drain();

    // R8: clamped tap counts
    for (int j = 0; j < MAXT; j++) wcoef(j, ((j * 37) % 200) - 100);
    set_cfg(0, 0);
    send(20000, "R8 taps0 as one");
    drain();
    chk("R8 taps0 latency", last_rise - last_acc, 2);
    set_cfg(511, 0);
    send(-15000, "R8 taps511 as 500");
    drain();
    chk("R8 taps511 latency", last_rise - last_acc, 51);
    set_cfg(500, 1);
    send(25000, "R8 taps500");
    drain();
    chk("R8 taps500 skip1 latency", last_rise - last_acc, 102);

    // R9: history survives tap changes
    set_cfg(3, 0);
    send(11111, "R9 short a");
    send(-22222, "R9 short b");
    set_cfg(20, 0);
    send(333, "R9 widened history");
    set_cfg(500, 0);
    send(-444, "R9 full history");
    drain();

    summary();
    $finish;
  end
endmodule